// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the slave side of a serial configuration port that gives a host access to a small file of 8-bit control registers. The host frames each transfer with an active-low select. It clocks in a 16-bit instruction and then one or more data bytes. The block writes the data bytes into the register file, or it returns register contents on the serial output. All port pins are sampled by the block's own clock through two-stage synchronizers. The serial clock must therefore run at a fraction of that clock, and its level is ignored while select is high.

The instruction carries a direction flag in bit 15 (1 = read, 0 = write). Bits 14:13 hold a byte count: codes 0, 1 and 2 move 1, 2 and 3 bytes, and code 3 streams bytes until select rises. Bits 12:0 hold the start address. Register 0 configures the port itself, and a change there takes effect at run time. Its bit 7 moves read data from the shared data pin to a separate output pin. Its bit 6 reverses the shift order, which also reverses the direction in which the address moves. Its bit 5 is a soft reset that is not stored. The host may raise select between two bytes of a counted transfer to pause it, and the transfer resumes when select falls again.

Top module: `spi_cfg_slave`

## Requirements
- R1: After reset all registers read 0, the data-pin output enable is low and the dedicated output pin is low.
- R2: With register 0 bit 6 clear, the instruction and the data bytes are shifted most-significant bit first on rising serial-clock edges. A write stores each byte at the current address, and the address then decrements by 1.
- R3: Count codes 0, 1 and 2 transfer exactly 1, 2 and 3 bytes. Any bytes the host sends after that have no effect.
- R4: Count code 3 keeps transferring bytes until select rises, and that rise ends the transfer. The next falling edge of select starts a new instruction.
- R5: In a counted transfer that still has bytes left, a rise of select pauses the transfer, and the transfer continues with the next byte after select falls. A byte with fewer than 8 bits received when select rises is discarded.
- R6: A read returns the addressed register contents, driven on the shared data pin and changed after falling serial-clock edges. The data-pin output enable is high only while select is low during the data phase of a read, and it stays low during the instruction.
- R7: When register 0 bit 7 is set, read data appears on the dedicated output pin and the data-pin output enable stays low. When the bit is clear, the dedicated output pin stays low.
- R8: A new value of register 0 bit 6 takes effect from the first instruction after select next rises. With the bit set, bits are shifted least-significant bit first (instruction bit 0 first) and the address increments by 1 after each byte.
- R9: Writing 1 to register 0 bit 5 returns every register, including register 0, to 0. Bit 5 always reads 0, and the next transfer uses most-significant-bit-first order and three-wire output.
- R10: Writes to addresses at or above the register count change nothing, and reads from those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low transfer select |
| spi_din | input | 1 | Input side of the shared data pin |
| spi_dout | output | 1 | Output side of the shared data pin |
| spi_dout_oe | output | 1 | Output enable of the shared data pin |
| spi_sdo | output | 1 | Dedicated read-data pin for four-wire mode |
| cfg_regs | output | NREG*8 | All registers flattened, register i at bits 8i+7:8i |

## Verification
The assertions check on every cycle that the data-pin enable is never high in four-wire mode or while select is high. They also check that the dedicated pin stays quiet in three-wire mode, that the soft-reset bit never reads back as set, and that registers change only while select is low. Only the bench scenarios can show the following: the addresses that byte counts and streaming reach, the two shift orders, the decrementing and incrementing address order, stalls that discard a partial byte, ignored out-of-range addresses, and the returned read bytes that the scoreboard compares.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int ADDR_W   = 13;
  localparam int CMD_W    = 16;
  localparam int BIT_4W   = 7;
  localparam int BIT_LSB  = 6;
  localparam int BIT_SRST = 5;

  typedef enum logic [1:0] {
    ST_INSTR = 2'd0,
    ST_DATA  = 2'd1,
    ST_DONE  = 2'd2
  } spi_state_e;
endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/spi_cfg_regfile.sv
module spi_cfg_regfile
  import spi_cfg_pkg::*;
#(
  parameter int NREG = 16,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rdata,
  output logic              cfg_lsb,
  output logic              cfg_4w,
  output logic [NREG*8-1:0] regs_flat
);
  logic [7:0] regs_q [NREG];
  logic       hit_w, soft_clr;

  assign hit_w    = we && (waddr < ADDR_W'(NREG));
  assign soft_clr = we && (waddr == '0) && wdata[BIT_SRST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= 8'h00;
    end else if (soft_clr) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= 8'h00;
    end else if (hit_w) begin
      if (waddr == '0) regs_q[0] <= wdata & ~(8'h01 << BIT_SRST);
      else             regs_q[waddr[IW-1:0]] <= wdata;
    end
  end

  assign rdata   = (rd_addr < ADDR_W'(NREG)) ? regs_q[rd_addr[IW-1:0]] : 8'h00;
  assign cfg_lsb = regs_q[0][BIT_LSB];
  assign cfg_4w  = regs_q[0][BIT_4W];

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_flat[g*8 +: 8] = regs_q[g];
  end
endmodule

// File: rtl/spi_cfg_ctrl.sv
module spi_cfg_ctrl
  import spi_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              csn_s,
  input  logic              din_s,
  input  logic [7:0]        rdata,
  input  logic              cfg_lsb,
  input  logic              cfg_4w,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [7:0]        wdata,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              dout,
  output logic              dout_oe,
  output logic              sdo
);
  spi_state_e        state_q, state_n;
  logic [3:0]        bcnt_q, bcnt_n;
  logic [CMD_W-1:0]  sh_q, sh_n, instr_w;
  logic [7:0]        byte_w, tx_q, tx_n;
  logic              rd_q, rd_n, strm_q, strm_n, lsb_q, lsb_n;
  logic [1:0]        left_q, left_n;
  logic [ADDR_W-1:0] addr_q, addr_n, step;
  logic              sclk_d, csn_d, sclk_rise, sclk_fall, cs_rise, rphase, dbit;

  assign sclk_rise = sclk_s && !sclk_d && !csn_s;
  assign sclk_fall = !sclk_s && sclk_d && !csn_s;
  assign cs_rise   = csn_s && !csn_d;

  assign instr_w = lsb_q ? {din_s, sh_q[CMD_W-1:1]} : {sh_q[CMD_W-2:0], din_s};
  assign byte_w  = lsb_q ? {din_s, sh_q[7:1]} : {sh_q[6:0], din_s};
  assign step    = lsb_q ? addr_q + 1'b1 : addr_q - 1'b1;

  always_comb begin
    state_n = state_q;  bcnt_n = bcnt_q;  sh_n = sh_q;  tx_n = tx_q;
    rd_n = rd_q;  strm_n = strm_q;  lsb_n = lsb_q;  left_n = left_q;
    addr_n = addr_q;  rd_addr = addr_q;
    we = 1'b0;  waddr = addr_q;  wdata = byte_w;
    if (cs_rise) begin
      bcnt_n = '0;
      lsb_n  = cfg_lsb;
      if (state_q == ST_DONE || (state_q == ST_DATA && strm_q)) state_n = ST_INSTR;
    end else if (sclk_rise) begin
      case (state_q)
        ST_INSTR: begin
          sh_n = instr_w;
          if (bcnt_q == 4'd15) begin
            bcnt_n  = '0;
            state_n = ST_DATA;
            rd_n    = instr_w[15];
            strm_n  = &instr_w[14:13];
            left_n  = instr_w[14:13];
            addr_n  = instr_w[ADDR_W-1:0];
            rd_addr = instr_w[ADDR_W-1:0];
            if (instr_w[15]) tx_n = rdata;
          end else begin
            bcnt_n = bcnt_q + 4'd1;
          end
        end
        ST_DATA: begin
          sh_n[7:0] = byte_w;
          if (bcnt_q == 4'd7) begin
            bcnt_n  = '0;
            we      = !rd_q;
            addr_n  = step;
            rd_addr = step;
            if (rd_q) tx_n = rdata;
            if (!strm_q) begin
              if (left_q == 2'd0) state_n = ST_DONE;
              else                left_n  = left_q - 2'd1;
            end
          end else begin
            bcnt_n = bcnt_q + 4'd1;
          end
        end
        default: ;
      endcase
    end else if (sclk_fall && state_q == ST_DATA && rd_q && bcnt_q != 4'd0) begin
      tx_n = lsb_q ? {1'b0, tx_q[7:1]} : {tx_q[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_INSTR;  bcnt_q <= '0;  sh_q <= '0;  tx_q <= '0;
      rd_q <= 1'b0;  strm_q <= 1'b0;  lsb_q <= 1'b0;  left_q <= '0;
      addr_q <= '0;  sclk_d <= 1'b0;  csn_d <= 1'b1;
    end else begin
      state_q <= state_n;  bcnt_q <= bcnt_n;  sh_q <= sh_n;  tx_q <= tx_n;
      rd_q <= rd_n;  strm_q <= strm_n;  lsb_q <= lsb_n;  left_q <= left_n;
      addr_q <= addr_n;  sclk_d <= sclk_s;  csn_d <= csn_s;
    end
  end

  assign rphase  = (state_q == ST_DATA) && rd_q && !csn_s;
  assign dbit    = lsb_q ? tx_q[0] : tx_q[7];
  assign dout    = dbit;
  assign dout_oe = rphase && !cfg_4w;
  assign sdo     = (rphase && cfg_4w) ? dbit : 1'b0;
endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_din,
  output logic              spi_dout,
  output logic              spi_dout_oe,
  output logic              spi_sdo,
  output logic [NREG*8-1:0] cfg_regs
);
  logic [1:0]        rst_sq;
  logic              rst_n_s;
  logic              sclk_s, csn_s, din_s, we, cfg_lsb, cfg_4w;
  logic [ADDR_W-1:0] waddr, rd_addr;
  logic [7:0]        wdata, rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_n_s = rst_sq[1];

  spi_cfg_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n_s),
    .d({spi_sclk, spi_cs_n, spi_din}),
    .q({sclk_s, csn_s, din_s})
  );

  spi_cfg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .sclk_s(sclk_s), .csn_s(csn_s), .din_s(din_s),
    .rdata(rdata), .cfg_lsb(cfg_lsb), .cfg_4w(cfg_4w),
    .we(we), .waddr(waddr), .wdata(wdata), .rd_addr(rd_addr),
    .dout(spi_dout), .dout_oe(spi_dout_oe), .sdo(spi_sdo)
  );

  spi_cfg_regfile #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .we(we), .waddr(waddr), .wdata(wdata),
    .rd_addr(rd_addr), .rdata(rdata), .cfg_lsb(cfg_lsb), .cfg_4w(cfg_4w),
    .regs_flat(cfg_regs)
  );
endmodule

// File: rtl/spi_cfg_slave_chk.sv
module spi_cfg_slave_chk #(
  parameter int NREG = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csn_s,
  input logic              oe,
  input logic              sdo,
  input logic [NREG*8-1:0] regs
);
  // R7: the shared pin is never enabled in four-wire mode
  a_r7_oe_three_wire_only: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> !regs[7]);
  // R7: dedicated pin is quiet in three-wire mode
  a_r7_sdo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !regs[7] |-> !sdo);
  // R6: no drive while select is high
  a_r6_oe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |-> !oe);
  // R9: soft-reset bit never reads back set
  a_r9_srst_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !regs[5]);
  // R2: registers change only inside a selected transfer
  a_r2_write_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs) |-> $past(!csn_s));
endmodule

bind spi_cfg_slave spi_cfg_slave_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .csn_s(csn_s), .oe(spi_dout_oe),
  .sdo(spi_sdo), .regs(cfg_regs)
);

// File: tb/test_spi_cfg_slave.sv
module test_spi_cfg_slave;
  localparam int CLK_P = 10;
  localparam int HALF  = 6;
  localparam int NREG  = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, din = 1'b0;
  logic dout, oe, sdo;
  logic [NREG*8-1:0] regs, snap;

  int   errors = 0, checks = 0;
  bit   lsb_mode = 0, four_w = 0, last_oe = 0;
  logic [7:0] txb [8];
  logic [7:0] cap;
  event cap_ev;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #(CLK_P/2) clk = ~clk;

  spi_cfg_slave #(.NREG(NREG)) i_spi_cfg_slave (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(csn), .spi_din(din),
    .spi_dout(dout), .spi_dout_oe(oe), .spi_sdo(sdo), .cfg_regs(regs)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rv(input int i);
    return regs[i*8 +: 8];
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, output logic r);
    din = b;
    wclk(HALF);
    r = four_w ? sdo : dout;
    last_oe = oe;
    sclk = 1'b1;
    wclk(HALF);
    sclk = 1'b0;
  endtask

  task automatic xfer(input bit rd, input logic [1:0] cnt, input logic [12:0] a,
                      input int nb, input bit stall, input int junk);
    logic [15:0] w;
    logic [7:0]  got;
    logic        r;
    w = {rd, cnt, a};
    csn = 1'b0;
    wclk(HALF);
    for (int i = 0; i < 16; i++) begin
      send_bit(w[lsb_mode ? i : 15 - i], r);
      if (rd && i == 15) check(last_oe == 1'b0, "R6 oe in instruction", last_oe, 0);
    end
    for (int k = 0; k < nb; k++) begin
      if (stall && k > 0) begin
        csn = 1'b1; wclk(2*HALF); csn = 1'b0; wclk(HALF);
        if (junk > 0) begin
          for (int j = 0; j < junk; j++) send_bit(1'b1, r);
          csn = 1'b1; wclk(2*HALF); csn = 1'b0; wclk(HALF);
        end
      end
      got = '0;
      for (int j = 0; j < 8; j++) begin
        int idx;
        idx = lsb_mode ? j : 7 - j;
        send_bit(rd ? 1'b0 : txb[k][idx], r);
        got[idx] = r;
      end
      if (rd) begin
        check(last_oe == !four_w, "R6/R7 oe in read data", last_oe, !four_w);
        cap = got;
        ->cap_ev;
        wclk(1);
      end
    end
    din = 1'b0;
    csn = 1'b1;
    wclk(3*HALF);
  endtask

  task automatic expect_rd(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // monitor: pops expected read bytes as the design returns them
  initial begin
    forever begin
      @(cap_ev);
      if (exp_q.size() == 0) begin
        check(1'b0, "scoreboard unexpected byte", cap, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(cap == e, t, cap, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wclk(4);
    rst_n = 1'b1;
    wclk(6);
    // R1 reset state
    check(regs == '0, "R1 regs", 32'(regs[31:0]), 0);
    check(oe == 1'b0, "R1 oe", oe, 0);
    check(sdo == 1'b0, "R1 sdo", sdo, 0);

    // R2 R3: three bytes, MSB first, decrementing
    txb[0] = 8'hA1; txb[1] = 8'hB2; txb[2] = 8'hC3;
    xfer(0, 2'd2, 13'd5, 3, 0, 0);
    check(rv(5) == 8'hA1, "R2 reg5", rv(5), 8'hA1);
    check(rv(4) == 8'hB2, "R2 reg4", rv(4), 8'hB2);
    check(rv(3) == 8'hC3, "R3 reg3", rv(3), 8'hC3);

    // R3: count 0 moves one byte, extra byte ignored
    txb[0] = 8'h11; txb[1] = 8'h22;
    xfer(0, 2'd0, 13'd7, 2, 0, 0);
    check(rv(7) == 8'h11, "R3 reg7", rv(7), 8'h11);
    check(rv(6) == 8'h00, "R3 reg6 untouched", rv(6), 0);

    // R6: three-wire read of two bytes
    expect_rd(8'hA1, "R6 read reg5");
    expect_rd(8'hB2, "R6 read reg4");
    xfer(1, 2'd1, 13'd5, 2, 0, 0);

    // R5: stall between bytes with a partial byte discarded
    txb[0] = 8'h5A; txb[1] = 8'h66;
    xfer(0, 2'd1, 13'd9, 2, 1, 3);
    check(rv(9) == 8'h5A, "R5 reg9", rv(9), 8'h5A);
    check(rv(8) == 8'h66, "R5 reg8 after stall", rv(8), 8'h66);

    // R4: streaming ends at select rise, next instruction works
    txb[0] = 8'h13; txb[1] = 8'h12; txb[2] = 8'h11;
    xfer(0, 2'd3, 13'd13, 3, 0, 0);
    check(rv(13) == 8'h13, "R4 reg13", rv(13), 8'h13);
    check(rv(11) == 8'h11, "R4 reg11", rv(11), 8'h11);
    txb[0] = 8'h44;
    xfer(0, 2'd0, 13'd14, 1, 0, 0);
    check(rv(14) == 8'h44, "R4 next transfer", rv(14), 8'h44);

    // R7: four-wire mode
    txb[0] = 8'h80;
    xfer(0, 2'd0, 13'd0, 1, 0, 0);
    check(rv(0) == 8'h80, "R7 reg0", rv(0), 8'h80);
    four_w = 1;
    expect_rd(8'h5A, "R7 read on sdo");
    xfer(1, 2'd0, 13'd9, 1, 0, 0);

    // R8: LSB first from next transfer, incrementing address
    txb[0] = 8'hC0;
    xfer(0, 2'd0, 13'd0, 1, 0, 0);
    lsb_mode = 1;
    txb[0] = 8'h12; txb[1] = 8'h34;
    xfer(0, 2'd1, 13'd10, 2, 0, 0);
    check(rv(10) == 8'h12, "R8 reg10", rv(10), 8'h12);
    check(rv(11) == 8'h34, "R8 reg11 increment", rv(11), 8'h34);
    expect_rd(8'h12, "R8 read reg10");
    expect_rd(8'h34, "R8 read reg11");
    xfer(1, 2'd1, 13'd10, 2, 0, 0);

    // R10: out-of-range address
    snap = regs;
    txb[0] = 8'hFF;
    xfer(0, 2'd0, 13'd100, 1, 0, 0);
    check(regs == snap, "R10 write ignored", 32'(regs[31:0]), 32'(snap[31:0]));
    expect_rd(8'h00, "R10 read out of range");
    xfer(1, 2'd0, 13'd100, 1, 0, 0);

    // R9: soft reset
    txb[0] = 8'h20;
    xfer(0, 2'd0, 13'd0, 1, 0, 0);
    check(regs == '0, "R9 all cleared", 32'(regs[31:0]), 0);
    lsb_mode = 0; four_w = 0;
    txb[0] = 8'h77;
    xfer(0, 2'd0, 13'd3, 1, 0, 0);
    check(rv(3) == 8'h77, "R9 msb order restored", rv(3), 8'h77);
    expect_rd(8'h77, "R9 three-wire read restored");
    xfer(1, 2'd0, 13'd3, 1, 0, 0);

    wclk(4);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule